// File: doc/BRIEF.md
# Keyed Watchdog Timer with Settings-Level Reset Request

This block watches over software by counting clock cycles from the moment software first writes its control register. The count is restarted only when software writes one exact key byte (0xA5) to a separate restart register. If the selected period runs out before such a write arrives, the block raises a request for a settings-level (INIT) reset. It holds that request until the reset system reports that an INIT or an RST reset has taken place.

When the INIT that follows is caused by the watchdog, the block sets a sticky watchdog bit in the reset-source register. While that INIT is active, it also drives a marker so that downstream logic can keep the oscillator stabilization wait setting. Once started, the timer cannot be stopped by software. Only a reset, either an observed INIT/RST or the power-on `rst_n`, returns it to the stopped state.

The four periods are powers of two: 2^(BASE_SHIFT + STEP*sel) clocks. With the default parameters these are 2^12, 2^14, 2^16 and 2^18 clocks for sel = 0..3.

Top module: `keyed_wdt`

## Requirements
- R1: After `rst_n` is low, `init_req`, `wdog_flag`, `osc_keep` and `running` are 0, and `period` is 0.
- R2: A control write while stopped sets `running`. With no key write, `init_req` rises exactly 2^(BASE_SHIFT+STEP*sel) clock edges after the write edge, and `running` falls on the same edge.
- R3: The period field is bits 9:8 of `ctrl_wdata`. Only the first control write after a reset latches it into `period`. Later writes leave `period` unchanged.
- R4: A write of 0xA5 to the restart register while running restarts the count. `init_req` then rises a full period after that write edge.
- R5: A restart-register write of any value other than 0xA5 has no effect on the count or on the moment `init_req` rises.
- R6: `init_req` stays high until `init_seen` or `rst_seen` is sampled high. It is low from the following edge, and after that clear the timer is stopped and the period field is unlocked.
- R7: `wdog_flag` (reset-source bit 13) is set on the edge where `init_seen` is sampled while `init_req` is high. It stays set until `rst_n`, and an RST alone never sets it.
- R8: `osc_keep` is high exactly while `init_seen` is high together with a pending `init_req`. It is low for an RST or for an INIT with no pending request.
- R9: A control write while running neither stops nor restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | CTRL_W | Control write data; bits 9:8 hold the period select |
| pst_we | input | 1 | Restart register write strobe |
| pst_wdata | input | 8 | Restart register write data |
| init_seen | input | 1 | An INIT reset is being applied |
| rst_seen | input | 1 | An RST reset is being applied |
| init_req | output | 1 | Settings-level reset request |
| wdog_flag | output | 1 | Reset-source watchdog bit (bit 13) |
| osc_keep | output | 1 | Marks the current INIT as watchdog-caused |
| running | output | 1 | Timer is counting |
| period | output | 2 | Latched period select |

## Verification
A write taken at a clock edge produces `running` and a latched `period` one edge later. The request rises exactly one period of edges after the last start or valid key edge. The bench drives on falling edges, so each check falls half a cycle after the edge that should have changed the output. The bench reads `init_req` one cycle before its due edge, where it must still be low, and again at the due edge, where it must be high. Clearing and `wdog_flag` are checked one edge after `init_seen` or `rst_seen`. `osc_keep` is combinational and is checked during the same low clock phase in which `init_seen` is driven.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int          BASE_SHIFT = 12,
  parameter int          STEP       = 2,
  parameter int          CTRL_W     = 16,
  parameter int          SEL_LSB    = 8,
  parameter logic [7:0]  KEY        = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              pst_we,
  input  logic [7:0]        pst_wdata,
  input  logic              init_seen,
  input  logic              rst_seen,
  output logic              init_req,
  output logic              wdog_flag,
  output logic              osc_keep,
  output logic              running,
  output logic [1:0]        period
);
  localparam int CW = BASE_SHIFT + 3 * STEP;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          locked;
  logic          key_ok;
  logic          any_rst;
  logic          expire;

  assign limit    = {CW{1'b1}} >> (STEP * (3 - int'(period)));
  assign key_ok   = pst_we && (pst_wdata == KEY);
  assign any_rst  = init_seen || rst_seen;
  assign expire   = running && (cnt == limit);
  assign osc_keep = init_seen && init_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      locked    <= 1'b0;
      period    <= 2'd0;
      cnt       <= '0;
      init_req  <= 1'b0;
      wdog_flag <= 1'b0;
    end else begin
      if (init_seen && init_req) wdog_flag <= 1'b1;
      if (any_rst) begin
        running  <= 1'b0;
        locked   <= 1'b0;
        period   <= 2'd0;
        cnt      <= '0;
        init_req <= 1'b0;
      end else begin
        if (ctrl_we && !locked) begin
          period <= ctrl_wdata[SEL_LSB +: 2];
          locked <= 1'b1;
        end
        if (ctrl_we && !running && !init_req) begin
          running <= 1'b1;
          cnt     <= '0;
        end else if (running) begin
          if (key_ok)      cnt <= '0;
          else if (expire) begin
            running  <= 1'b0;
            init_req <= 1'b1;
          end else         cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init_req && !any_rst |=> init_req);

  p_req_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_rst |=> !init_req && !running);

  p_req_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_req) |-> $past(running));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_flag |=> wdog_flag);

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_seen && init_req |=> wdog_flag);

  p_period_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !any_rst |=> $stable(period));

  p_key_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    running && key_ok && !any_rst |=> cnt == '0);

  p_bad_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    running && pst_we && !key_ok && !expire && !any_rst |=> cnt == $past(cnt) + 1'b1);

  p_no_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    running && !expire && !any_rst |=> running);
endmodule

// File: tb/sim_keyed_wdt.sv
module sim_keyed_wdt;
  localparam int BASE = 4;
  localparam int STP  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic        pst_we = 1'b0;
  logic [7:0]  pst_wdata = '0;
  logic        init_seen = 1'b0;
  logic        rst_seen = 1'b0;
  logic        init_req, wdog_flag, osc_keep, running;
  logic [1:0]  period;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  keyed_wdt #(.BASE_SHIFT(BASE), .STEP(STP)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .pst_we(pst_we), .pst_wdata(pst_wdata), .init_seen(init_seen),
    .rst_seen(rst_seen), .init_req(init_req), .wdog_flag(wdog_flag),
    .osc_keep(osc_keep), .running(running), .period(period));

  function automatic int per(input int sel);
    return 1 << (BASE + STP * sel);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic por();
    @(negedge clk);
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic wr_ctrl(input logic [1:0] sel);
    ctrl_wdata = 16'h0000;
    ctrl_wdata[9:8] = sel;
    ctrl_we = 1'b1;
    cyc(1);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_pst(input logic [7:0] v);
    pst_wdata = v;
    pst_we = 1'b1;
    cyc(1);
    pst_we = 1'b0;
  endtask

  task automatic expect_req(input string req, input int n);
    cyc(n - 1);
    chk(req, int'(init_req), 0);
    cyc(1);
    chk(req, int'(init_req), 1);
    chk(req, int'(running), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cyc(2);
    chk("R1", int'(init_req), 0);
    chk("R1", int'(wdog_flag), 0);
    chk("R1", int'(osc_keep), 0);
    chk("R1", int'(running), 0);
    chk("R1", int'(period), 0);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic t_timeout(input logic [1:0] sel);
    por();
    cyc(3);
    chk("R2", int'(running), 0);
    wr_ctrl(sel);
    chk("R2", int'(running), 1);
    chk("R3", int'(period), int'(sel));
    expect_req("R2", per(int'(sel)));
  endtask

  task automatic t_key();
    por();
    wr_ctrl(2'd0);
    cyc(10);
    wr_pst(8'hA5);
    cyc(10);
    wr_pst(8'hA5);
    expect_req("R4", per(0));
  endtask

  task automatic t_bad_key();
    por();
    wr_ctrl(2'd0);
    cyc(4);
    wr_pst(8'h5A);
    cyc(4);
    wr_pst(8'hA4);
    expect_req("R5", per(0) - 10);
  endtask

  task automatic t_lock();
    por();
    wr_ctrl(2'd2);
    chk("R3", int'(period), 2);
    cyc(5);
    wr_ctrl(2'd1);
    chk("R3", int'(period), 2);
    chk("R9", int'(running), 1);
    expect_req("R9", per(2) - 6);
  endtask

  task automatic t_clear_init();
    por();
    wr_ctrl(2'd0);
    expect_req("R2", per(0));
    cyc(20);
    chk("R6", int'(init_req), 1);
    chk("R7", int'(wdog_flag), 0);
    chk("R8", int'(osc_keep), 0);
    init_seen = 1'b1;
    #1;
    chk("R8", int'(osc_keep), 1);
    cyc(1);
    init_seen = 1'b0;
    chk("R6", int'(init_req), 0);
    chk("R6", int'(running), 0);
    chk("R7", int'(wdog_flag), 1);
    init_seen = 1'b1;
    #1;
    chk("R8", int'(osc_keep), 0);
    cyc(1);
    init_seen = 1'b0;
    chk("R7", int'(wdog_flag), 1);
    wr_ctrl(2'd1);
    chk("R6", int'(period), 1);
    expect_req("R6", per(1));
    rst_seen = 1'b1;
    cyc(1);
    rst_seen = 1'b0;
    chk("R7", int'(wdog_flag), 1);
  endtask

  task automatic t_clear_rst();
    por();
    wr_ctrl(2'd0);
    expect_req("R2", per(0));
    rst_seen = 1'b1;
    #1;
    chk("R8", int'(osc_keep), 0);
    cyc(1);
    rst_seen = 1'b0;
    chk("R6", int'(init_req), 0);
    chk("R7", int'(wdog_flag), 0);
    cyc(per(0) + 4);
    chk("R6", int'(init_req), 0);
    chk("R6", int'(running), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(1);
    t_reset();
    for (int s = 0; s < 4; s++) t_timeout(2'(s));
    t_key();
    t_bad_key();
    t_lock();
    t_clear_init();
    t_clear_rst();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule